// File: doc/BRIEF.md
# Branch Source Trace Queue

This block keeps a short history of control flow for on-chip debug. Each time the core reports a taken branch while tracing is enabled, the low address bits of the branching instruction are pushed onto the head of an eight-deep shift queue, and every older record moves one place toward the tail. Software reads the history back through a single read-only register slot. Each read returns the newest unread record and then advances the queue, so successive reads walk backward in time until only empty records remain.

Every record carries a valid flag. Power-on reset clears the flags, a fresh enabling of tracing clears them, and reading a record removes it. The stored address bits are deliberately left without reset, so a record's address is only meaningful while its flag is set. The read word carries the flag in its top bit, zeros in the three bits below it, and the stored address in the low 28 bits.

Top module: `brq_trace_queue`

## Requirements
- R1: When `br_valid` is 1 in a cycle with `trace_en` at 1, the next read word has bit 31 at 1 and bits 27:0 equal to `br_addr`.
- R2: The queue holds eight records. Each capture pushes older records one place toward the tail. Valid records always sit contiguously from the head.
- R3: A capture into a queue whose eight records are all valid drops the oldest record. The next eight reads return the eight newest captures, and a ninth read has bit 31 at 0.
- R4: A read, meaning `bus_sel`=1 with `bus_wr`=0, returns the head record combinationally in that cycle. From the next cycle on, the word shows the next older record, and an empty record enters at the tail.
- R5: Once every valid record has been read, further reads return bit 31 at 0.
- R6: While `trace_en` is 0, `br_valid` captures nothing and leaves the read word unchanged.
- R7: In the cycle where `trace_en` goes from 0 to 1, all eight valid flags clear at once. A branch in that same cycle is still captured as the only valid record.
- R8: When a read and a capture fall in the same cycle, the read returns the head as it stood before the branch. The new branch then becomes the head, and the records that were behind the old head keep their places.
- R9: Bits 30:28 of `rd_data` are always 0.
- R10: A bus write, meaning `bus_sel`=1 with `bus_wr`=1, changes no record.
- R11: After reset, all valid flags are 0, so `rd_data[31]` reads 0. The address bits are not initialised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset, released synchronously inside |
| trace_en | input | 1 | Trace enable; its rising edge clears all valid flags |
| br_valid | input | 1 | Taken-branch strobe, one per branch |
| br_addr | input | 28 | Low 28 bits of the branching instruction's address |
| bus_sel | input | 1 | Register-slot select strobe |
| bus_wr | input | 1 | 1 marks the access as a write (ignored), 0 as a read |
| rd_data | output | 32 | Head record: bit 31 valid, bits 30:28 zero, bits 27:0 address |

## Verification
The assertions check several rules on every cycle. A capture must appear at the head with the captured address on the next cycle. Valid flags must stay packed from the head, and a full queue must stay full under capture. A read must drop the valid count by exactly one, a trace-enable rise must wipe the flags, and idle or write-only cycles must leave the flags untouched. Other properties need a sequence of cycles and are shown only by the bench's scenarios: that reads return records newest first, that the ninth of nine captures evicts the oldest, that a read merged with a capture returns the pre-branch head and keeps the rest, and that the reserved bits stay zero. A bench model follows the queue through long random mixes of branches, reads, writes and enable toggles.

// File: rtl/brq_pkg.sv
package brq_pkg;

  // Queue operation selected for one cycle
  typedef enum logic [1:0] {
    BRQ_HOLD = 2'b00,  // nothing moves
    BRQ_PUSH = 2'b01,  // capture only: shift toward tail, new at head
    BRQ_POP  = 2'b10,  // read only: shift toward head, empty at tail
    BRQ_SWAP = 2'b11   // read and capture: replace head, rest hold
  } brq_op_e;

endpackage

// File: rtl/brq_ctrl.sv
module brq_ctrl
  import brq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    trace_en,
  input  logic    br_valid,
  input  logic    bus_sel,
  input  logic    bus_wr,
  output logic    rst_sync_n,
  output brq_op_e op,
  output logic    clr_all
);

  logic [1:0] sync_q;
  logic       te_q;
  logic       capture;
  logic       rd_req;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) te_q <= 1'b0;
    else             te_q <= trace_en;
  end

  assign capture = trace_en & br_valid;
  assign rd_req  = bus_sel & ~bus_wr;
  assign clr_all = trace_en & ~te_q;

  always_comb begin
    unique case ({rd_req, capture})
      2'b01:   op = BRQ_PUSH;
      2'b10:   op = BRQ_POP;
      2'b11:   op = BRQ_SWAP;
      default: op = BRQ_HOLD;
    endcase
  end

endmodule

// File: rtl/brq_store.sv
module brq_store
  import brq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  brq_op_e       op,
  input  logic          clr_all,
  input  logic [AW-1:0] new_addr,
  output logic          head_vld,
  output logic [AW-1:0] head_addr,
  output logic [DEPTH-1:0] vld_vec
);

  logic [AW-1:0] addr_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    localparam bit IS_HEAD = (i == 0);
    localparam bit IS_TAIL = (i == DEPTH - 1);

    logic          up_v, dn_v;
    logic [AW-1:0] up_a, dn_a;
    logic          sel_v;
    logic [AW-1:0] sel_a;
    logic          new_here;
    logic          v_nxt, a_en;
    logic          v_r;
    logic [AW-1:0] a_r;

    if (IS_HEAD) begin : g_up_new
      assign up_v = 1'b1;
      assign up_a = new_addr;
    end else begin : g_up_prev
      assign up_v = vld_vec[i-1];
      assign up_a = addr_q[i-1];
    end

    if (IS_TAIL) begin : g_dn_empty
      assign dn_v = 1'b0;
      assign dn_a = a_r;
    end else begin : g_dn_next
      assign dn_v = vld_vec[i+1];
      assign dn_a = addr_q[i+1];
    end

    // next-state selection
    always_comb begin
      sel_v = v_r;
      sel_a = a_r;
      a_en  = 1'b0;
      unique case (op)
        BRQ_PUSH: begin
          sel_v = up_v;
          sel_a = up_a;
          a_en  = 1'b1;
        end
        BRQ_POP: begin
          sel_v = dn_v;
          sel_a = dn_a;
          a_en  = !IS_TAIL;
        end
        BRQ_SWAP: begin
          if (IS_HEAD) begin
            sel_v = up_v;
            sel_a = up_a;
            a_en  = 1'b1;
          end
        end
        default: ;
      endcase
      new_here = IS_HEAD && ((op == BRQ_PUSH) || (op == BRQ_SWAP));
      v_nxt    = new_here ? 1'b1 : (sel_v & ~clr_all);
    end

    // flag register: reset
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_r <= 1'b0;
      else        v_r <= v_nxt;
    end

    // address register: no reset, explicit enable
    always_ff @(posedge clk) begin
      if (a_en) a_r <= sel_a;
    end

    assign vld_vec[i] = v_r;
    assign addr_q[i]  = a_r;
  end

  assign head_vld  = vld_vec[0];
  assign head_addr = addr_q[0];

endmodule

// File: rtl/brq_rdfmt.sv
module brq_rdfmt #(
  parameter int AW = 28,
  parameter int DW = 32
) (
  input  logic          head_vld,
  input  logic [AW-1:0] head_addr,
  output logic [DW-1:0] rd_data
);

  localparam int PADW = DW - 1 - AW;

  assign rd_data = {head_vld, {PADW{1'b0}}, head_addr};

endmodule

// File: rtl/brq_trace_queue.sv
module brq_trace_queue
  import brq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 28,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trace_en,
  input  logic          br_valid,
  input  logic [AW-1:0] br_addr,
  input  logic          bus_sel,
  input  logic          bus_wr,
  output logic [DW-1:0] rd_data
);

  logic             rst_sync_n;
  brq_op_e          op;
  logic             clr_all;
  logic             head_vld;
  logic [AW-1:0]    head_addr;
  logic [DEPTH-1:0] vld_vec;

  brq_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .trace_en   (trace_en),
    .br_valid   (br_valid),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .rst_sync_n (rst_sync_n),
    .op         (op),
    .clr_all    (clr_all)
  );

  brq_store #(.DEPTH(DEPTH), .AW(AW)) store_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .op        (op),
    .clr_all   (clr_all),
    .new_addr  (br_addr),
    .head_vld  (head_vld),
    .head_addr (head_addr),
    .vld_vec   (vld_vec)
  );

  brq_rdfmt #(.AW(AW), .DW(DW)) fmt_i (
    .head_vld  (head_vld),
    .head_addr (head_addr),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/brq_trace_queue_chk.sv
module brq_trace_queue_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 28,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             trace_en,
  input logic             br_valid,
  input logic [AW-1:0]    br_addr,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [DW-1:0]    rd_data,
  input logic [DEPTH-1:0] vld_vec
);

  logic cap, rd;
  assign cap = trace_en & br_valid;
  assign rd  = bus_sel & ~bus_wr;

  AST_CAPTURE_AT_HEAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cap |=> (rd_data[DW-1] && rd_data[AW-1:0] == $past(br_addr))); // R1

  AST_VALID_PACKED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((vld_vec & (vld_vec + 1'b1)) == '0)); // R2

  AST_FULL_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cap && !rd && !$rose(trace_en) && (&vld_vec)) |=> (&vld_vec)); // R3

  AST_READ_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd && !cap && !$rose(trace_en) && vld_vec[0])
      |=> ($countones(vld_vec) == $countones($past(vld_vec)) - 1)); // R4

  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!trace_en && !rd) |=> $stable(vld_vec)); // R6

  AST_ENABLE_WIPES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(trace_en) && !br_valid) |=> (vld_vec == '0)); // R7

  AST_SWAP_HEAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cap && rd && !$rose(trace_en))
      |=> ($countones(vld_vec) == (($past(vld_vec[0])) ? $countones($past(vld_vec))
                                                       : $countones($past(vld_vec)) + 1))); // R8

endmodule

bind brq_trace_queue brq_trace_queue_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .trace_en   (trace_en),
  .br_valid   (br_valid),
  .br_addr    (br_addr),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .rd_data    (rd_data),
  .vld_vec    (vld_vec)
);

// File: tb/brq_trace_queue_tb.sv
`timescale 1ns/1ps
module brq_trace_queue_tb_top;

  localparam int DEPTH = 8;
  localparam int AW    = 28;
  localparam int DW    = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          trace_en;
  logic          br_valid;
  logic [AW-1:0] br_addr;
  logic          bus_sel;
  logic          bus_wr;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model of the queue
  bit            m_v [DEPTH];
  logic [AW-1:0] m_a [DEPTH];
  bit            m_te;

  always #10 clk = ~clk;

  brq_trace_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut_i (
    .clk (clk), .rst_n (rst_n), .trace_en (trace_en), .br_valid (br_valid),
    .br_addr (br_addr), .bus_sel (bus_sel), .bus_wr (bus_wr), .rd_data (rd_data)
  );

  function automatic logic [DW-1:0] exp_word();
    return {m_v[0], 3'b000, m_a[0]};
  endfunction

  task automatic check_out(string req);
    logic [DW-1:0] e;
    bit bad;
    e = exp_word();
    checks++;
    bad = (rd_data[31] !== e[31]) || (rd_data[30:28] !== 3'b000) ||
          (e[31] && (rd_data[27:0] !== e[27:0]));
    if (bad) begin
      fails++;
      $display("FAIL %s: rd_data=%h expected=%h (address checked only when valid)",
               req, rd_data, e);
    end
  endtask

  task automatic model_step(bit br, logic [AW-1:0] a, bit te, bit sel, bit wr);
    bit rd, cap, rise;
    rd   = sel && !wr;
    cap  = br && te;
    rise = te && !m_te;
    if (rd && cap) begin
      m_v[0] = 1'b1; m_a[0] = a;
      if (rise) for (int k = 1; k < DEPTH; k++) m_v[k] = 1'b0;
    end else if (cap) begin
      for (int k = DEPTH - 1; k > 0; k--) begin
        m_v[k] = rise ? 1'b0 : m_v[k-1];
        m_a[k] = m_a[k-1];
      end
      m_v[0] = 1'b1; m_a[0] = a;
    end else if (rd) begin
      for (int k = 0; k < DEPTH - 1; k++) begin
        m_v[k] = rise ? 1'b0 : m_v[k+1];
        m_a[k] = m_a[k+1];
      end
      m_v[DEPTH-1] = 1'b0;
    end else if (rise) begin
      for (int k = 0; k < DEPTH; k++) m_v[k] = 1'b0;
    end
    m_te = te;
  endtask

  // one clock: drive at falling edge, compare before rising edge, then advance model
  task automatic step(bit br, logic [AW-1:0] a, bit te, bit sel, bit wr, string req);
    @(negedge clk);
    br_valid = br; br_addr = a; trace_en = te; bus_sel = sel; bus_wr = wr;
    #1;
    check_out(req);
    @(posedge clk);
    model_step(br, a, te, sel, wr);
  endtask

  task automatic idle(bit te, string req);
    step(1'b0, '0, te, 1'b0, 1'b0, req);
  endtask

  task automatic push(logic [AW-1:0] a, string req);
    step(1'b1, a, 1'b1, 1'b0, 1'b0, req);
  endtask

  task automatic rd(bit te, string req);
    step(1'b0, '0, te, 1'b1, 1'b0, req);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h5EED_0042;
    void'($urandom(seed));
    for (int k = 0; k < DEPTH; k++) begin m_v[k] = 1'b0; m_a[k] = '0; end
    m_te = 1'b0;
    rst_n = 1'b0; trace_en = 1'b0; br_valid = 1'b0; br_addr = '0;
    bus_sel = 1'b0; bus_wr = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check_out("R11 reset");
    rst_n = 1'b1;
    repeat (3) idle(1'b0, "R11 after reset");

    // R7 enable rise with nothing captured, then R1 captures and R4 ordered reads
    idle(1'b1, "R7");
    push(28'h000_0101, "R1");
    push(28'h0AB_CDEF, "R1");
    push(28'hFFF_FFFF, "R1");
    rd(1'b1, "R4 newest first");
    rd(1'b1, "R4 next older");
    rd(1'b1, "R4 oldest");
    rd(1'b1, "R5 empty read");
    rd(1'b1, "R5 empty read again");

    // R6 branches while disabled are dropped
    idle(1'b0, "R6");
    step(1'b1, 28'h123_4567, 1'b0, 1'b0, 1'b0, "R6");
    step(1'b1, 28'h765_4321, 1'b0, 1'b0, 1'b0, "R6");
    idle(1'b0, "R6 nothing captured");

    // R3 overflow: nine captures, eight reads, ninth read empty
    idle(1'b1, "R7 rise");
    for (int k = 0; k < 9; k++) push(28'h100_0000 + AW'(k * 3), "R3 fill");
    for (int k = 0; k < 8; k++) rd(1'b1, "R3 drain");
    rd(1'b1, "R3 oldest discarded");

    // R10 writes ignored, R8 read merged with capture
    push(28'h0000_011, "R1");
    push(28'h0000_022, "R1");
    step(1'b0, '0, 1'b1, 1'b1, 1'b1, "R10 write");
    step(1'b0, '0, 1'b1, 1'b1, 1'b1, "R10 write");
    idle(1'b1, "R10 head unchanged");
    step(1'b1, 28'h0000_033, 1'b1, 1'b1, 1'b0, "R8 pre-branch head");
    rd(1'b1, "R8 new head");
    rd(1'b1, "R8 older kept");
    rd(1'b1, "R8 then empty");

    // R7 rise with a branch in the same cycle
    push(28'h0000_044, "R1");
    push(28'h0000_055, "R1");
    idle(1'b0, "R7 disable");
    step(1'b1, 28'h0000_066, 1'b1, 1'b0, 1'b0, "R7 rise with branch");
    rd(1'b1, "R7 only new entry");
    rd(1'b1, "R7 rest cleared");

    // R2 random mix against the model; R9 checked on every word
    for (int n = 0; n < 4000; n++) begin
      bit te, br, sel, wr;
      te  = (($urandom % 40) == 0) ? !m_te : m_te;
      br  = ($urandom % 2) == 0;
      sel = ($urandom % 3) == 0;
      wr  = ($urandom % 2) == 0;
      step(br, AW'($urandom), te, sel, wr, "R2 R9 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule